// File: doc/BRIEF.md
# Content-Addressed Memory Page Mapper

The mapper turns a 32-bit logical byte address into a 19-bit physical address for a memory built as four chip rows, each holding four blocks of 4K words. It keeps sixteen mapper entries. Each entry holds a 15-bit logical page tag, a retire flag, a 2-bit chip-row code and three upper row-address bits. Software or a loader fills the entries through a simple write port.

On each request, the page field of the address is compared against every entry at once. If an entry matches and its retire flag is clear, the mapper drives one chip-row select and presents the physical address in the same cycle. If nothing matches, or the matching entry is retired, nothing is selected. In both of those cases a registered fault flag rises on the following cycle. Retiring an entry takes a defective block out of service, and no logical page can then reach it.

Top module: `cam_page_mapper`

## Requirements
- R1: After reset every entry is retired with tag 0, so before any write a request to page 0 selects no chip row and raises the fault.
- R2: A write with `wr_en` high stores tag, retire flag, row code and upper Y bits into the entry `wr_idx` at the clock edge, replacing what that entry held.
- R3: The page field is `laddr[28:14]`. A request whose page matches no entry gives `cs` = 0 and `paddr` = 0. `laddr[31:29]` takes no part in the compare.
- R4: A request whose page matches a retired entry gives `cs` = 0 and `paddr` = 0.
- R5: A request matching a non-retired entry drives exactly one select, `cs[row]`, where `row` is that entry's 2-bit row code. `paddr[18:17]` carries the same row code.
- R6: The Y address `paddr[16:10]` is the entry's three upper bits (in `paddr[16:14]`) joined above `laddr[13:10]` (in `paddr[13:10]`).
- R7: The X address `paddr[9:2]` equals `laddr[9:2]`, and the byte offset `paddr[1:0]` equals `laddr[1:0]`.
- R8: `fault` is registered. One cycle after a request that misses or hits a retired entry it is 1. After a good hit, or after a cycle with no request, it is 0.
- R9: When several entries hold the matching tag, the lowest-index entry alone decides the result, including its retire flag.
- R10: While `req` is low, `cs` and `paddr` are 0 whatever the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load one mapper entry |
| wr_idx | input | 4 | Entry index to load |
| wr_tag | input | 15 | Logical page tag |
| wr_mapout | input | 1 | Retire flag (1 = block unusable) |
| wr_row | input | 2 | Chip-row code |
| wr_yhi | input | 3 | Upper Y bits (bit 2 unused by memory, bits 1:0 pick the block) |
| req | input | 1 | Lookup request |
| laddr | input | 32 | Logical byte address |
| cs | output | 4 | One-hot chip-row select |
| paddr | output | 19 | {row, Y[6:0], X[7:0], byte[1:0]} |
| fault | output | 1 | Registered: previous request was refused |

## Verification
On every cycle the assertions check that `cs` is never more than one-hot and agrees with the row code in `paddr`. They also check that an idle request leaves the outputs quiet, that X and the low Y bits pass through on a hit, and that `fault` follows the request outcome one cycle later. Which entry is chosen, and the tag, retire and priority rules behind that choice, can only be shown by the bench's scenarios. Those scenarios cover a miss, a retired hit, a hit on each chip row, an entry rewrite, and two duplicate-tag cases in which the lower entry is good in one and retired in the other.

// File: rtl/cam_page_mapper.sv
module cam_page_mapper #(
  parameter int ENTRIES = 16,
  parameter int ROWS    = 4,
  parameter int FNW     = 3,
  parameter int PAGEW   = 15,
  parameter int YHIW    = 3,
  parameter int YLOW    = 4,
  parameter int XW      = 8,
  parameter int BW      = 2,
  localparam int IDXW   = $clog2(ENTRIES),
  localparam int ROWW   = $clog2(ROWS),
  localparam int AW     = FNW + PAGEW + YLOW + XW + BW,
  localparam int PAW    = ROWW + YHIW + YLOW + XW + BW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDXW-1:0]  wr_idx,
  input  logic [PAGEW-1:0] wr_tag,
  input  logic             wr_mapout,
  input  logic [ROWW-1:0]  wr_row,
  input  logic [YHIW-1:0]  wr_yhi,
  input  logic             req,
  input  logic [AW-1:0]    laddr,
  output logic [ROWS-1:0]  cs,
  output logic [PAW-1:0]   paddr,
  output logic             fault
);

  localparam int PAGE_LO = YLOW + XW + BW;
  localparam int YLO_LO  = XW + BW;

  logic [PAGEW-1:0] tag_q [ENTRIES];
  logic             mo_q  [ENTRIES];
  logic [ROWW-1:0]  row_q [ENTRIES];
  logic [YHIW-1:0]  yhi_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i] <= '0;
        mo_q[i]  <= 1'b1;
        row_q[i] <= '0;
        yhi_q[i] <= '0;
      end
    end else if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      mo_q[wr_idx]  <= wr_mapout;
      row_q[wr_idx] <= wr_row;
      yhi_q[wr_idx] <= wr_yhi;
    end
  end

  logic [PAGEW-1:0] page;
  logic [ENTRIES-1:0] match;
  logic             hit;
  logic [IDXW-1:0]  sel;
  logic             ok;

  assign page = laddr[PAGE_LO +: PAGEW];

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = (tag_q[g] == page);
    end
  endgenerate

  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        sel = IDXW'(i);
      end
    end
  end

  assign ok    = req & hit & ~mo_q[sel];
  assign cs    = ok ? (ROWS'(1) << row_q[sel]) : '0;
  assign paddr = ok ? {row_q[sel], yhi_q[sel], laddr[YLO_LO +: YLOW], laddr[BW +: XW], laddr[BW-1:0]}
                    : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) fault <= 1'b0;
    else        fault <= req & ~ok;
  end

  AST_CS_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cs)); // R5
  AST_CS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (|cs) |-> (cs == (ROWS'(1) << paddr[PAW-1 -: ROWW]))); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> (cs == '0 && paddr == '0)); // R10
  AST_X_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (|cs) |-> (paddr[BW +: XW] == laddr[BW +: XW] && paddr[BW-1:0] == laddr[BW-1:0])); // R7
  AST_Y_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (|cs) |-> (paddr[YLO_LO +: YLOW] == laddr[YLO_LO +: YLOW])); // R6
  AST_FAULT_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (req && cs == '0) |=> fault); // R8
  AST_FAULT_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    (req && |cs) |=> !fault); // R8
  AST_FAULT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !fault); // R8

endmodule

// File: tb/cam_page_mapper_tb.sv
`timescale 1ns/1ps
module cam_page_mapper_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [14:0] wr_tag = '0;
  logic        wr_mapout = 1'b0;
  logic [1:0]  wr_row = '0;
  logic [2:0]  wr_yhi = '0;
  logic        req = 1'b0;
  logic [31:0] laddr = '0;
  logic [3:0]  cs;
  logic [18:0] paddr;
  logic        fault;

  always #4 clk = ~clk;

  cam_page_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
    .wr_mapout(wr_mapout), .wr_row(wr_row), .wr_yhi(wr_yhi), .req(req),
    .laddr(laddr), .cs(cs), .paddr(paddr), .fault(fault)
  );

  typedef struct {
    logic [3:0]  cs;
    logic [18:0] pa;
    logic        flt;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic logic [31:0] mkaddr(logic [2:0] fn, logic [14:0] pg, logic [3:0] ylo,
                                         logic [7:0] x, logic [1:0] b);
    return {fn, pg, ylo, x, b};
  endfunction

  function automatic logic [18:0] expa(logic [1:0] row, logic [2:0] yhi, logic [31:0] a);
    return {row, yhi, a[13:10], a[9:2], a[1:0]};
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] idx, logic [14:0] tg, logic mo, logic [1:0] row, logic [2:0] yhi);
    @(negedge clk);
    req = 1'b0; wr_en = 1'b1; wr_idx = idx; wr_tag = tg;
    wr_mapout = mo; wr_row = row; wr_yhi = yhi;
  endtask

  task automatic look(logic r, logic [31:0] a, logic [3:0] ecs, logic [18:0] epa,
                      logic ef, string tag);
    item_t it;
    @(negedge clk);
    wr_en = 1'b0; req = r; laddr = a;
    it.cs = ecs; it.pa = epa; it.flt = ef; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic good(logic [31:0] a, logic [1:0] row, logic [2:0] yhi, string tag);
    look(1'b1, a, 4'b0001 << row, expa(row, yhi, a), 1'b0, tag);
  endtask

  task automatic bad(logic [31:0] a, string tag);
    look(1'b1, a, 4'b0, 19'b0, 1'b1, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk(it.tag, "cs", {28'b0, cs}, {28'b0, it.cs});
        chk(it.tag, "paddr", {13'b0, paddr}, {13'b0, it.pa});
        chk(it.tag, "fault", {31'b0, fault}, {31'b0, it.flt});
      end
    end
  end

  initial begin
    #1_600_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset cs", {28'b0, cs}, 32'h0);
    chk("R8", "reset fault", {31'b0, fault}, 32'h0);

    bad(mkaddr(3'd0, 15'h0000, 4'h3, 8'h12, 2'd1), "R1 page0 retired after reset");
    look(1'b0, mkaddr(3'd0, 15'h0000, 4'h3, 8'h12, 2'd1), 4'b0, 19'b0, 1'b0, "R10 idle");

    wr(4'd0, 15'h1A2B, 1'b0, 2'd0, 3'b101);
    wr(4'd1, 15'h0F0F, 1'b0, 2'd1, 3'b010);
    wr(4'd2, 15'h7001, 1'b0, 2'd2, 3'b111);
    wr(4'd3, 15'h2222, 1'b0, 2'd3, 3'b000);
    wr(4'd4, 15'h4444, 1'b1, 2'd2, 3'b011);
    wr(4'd5, 15'h1A2B, 1'b0, 2'd3, 3'b110);
    wr(4'd6, 15'h5555, 1'b0, 2'd1, 3'b001);
    wr(4'd7, 15'h5555, 1'b1, 2'd0, 3'b000);
    wr(4'd8, 15'h6666, 1'b1, 2'd0, 3'b000);
    wr(4'd9, 15'h6666, 1'b0, 2'd2, 3'b100);

    good(mkaddr(3'd0, 15'h1A2B, 4'hA, 8'h5C, 2'd2), 2'd0, 3'b101, "R5 R6 R7 R9 row0");
    good(mkaddr(3'd5, 15'h0F0F, 4'h1, 8'hFF, 2'd3), 2'd1, 3'b010, "R5 R3 row1 fn ignored");
    good(mkaddr(3'd7, 15'h7001, 4'hF, 8'h00, 2'd0), 2'd2, 3'b111, "R5 R6 row2");
    good(mkaddr(3'd2, 15'h2222, 4'h6, 8'hA5, 2'd1), 2'd3, 3'b000, "R5 R7 row3");
    bad(mkaddr(3'd0, 15'h3333, 4'h6, 8'hA5, 2'd1), "R3 miss");
    bad(mkaddr(3'd0, 15'h2223, 4'h6, 8'hA5, 2'd1), "R3 miss one bit off");
    bad(mkaddr(3'd0, 15'h4444, 4'h2, 8'h33, 2'd0), "R4 retired hit");
    good(mkaddr(3'd0, 15'h5555, 4'h9, 8'h81, 2'd2), 2'd1, 3'b001, "R9 low good over high retired");
    bad(mkaddr(3'd0, 15'h6666, 4'h9, 8'h81, 2'd2), "R9 low retired over high good");
    look(1'b0, mkaddr(3'd0, 15'h1A2B, 4'hA, 8'h5C, 2'd2), 4'b0, 19'b0, 1'b0, "R10 R8 idle after hit");
    bad(mkaddr(3'd0, 15'h0000, 4'h0, 8'h00, 2'd0), "R1 untouched entries still retired");

    wr(4'd3, 15'h2222, 1'b0, 2'd1, 3'b011);
    good(mkaddr(3'd0, 15'h2222, 4'h4, 8'h7E, 2'd3), 2'd1, 3'b011, "R2 rewrite entry");
    wr(4'd2, 15'h7001, 1'b1, 2'd2, 3'b111);
    bad(mkaddr(3'd0, 15'h7001, 4'hF, 8'h00, 2'd0), "R2 R4 entry retired by write");
    good(mkaddr(3'd0, 15'h0F0F, 4'h0, 8'h01, 2'd0), 2'd1, 3'b010, "R8 good after refusal");

    @(negedge clk);
    req = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule